// File: doc/BRIEF.md
# Low-Power Data Bus Keeper Controller

This block manages the pins of a data bus (16 data bits plus 2 parity bits by default) while a processor moves between its running, stop-grant and stop-clock power states. For every pin it produces a keeper enable, an output enable and the level the keeper drives back onto the pin. The kept level follows whatever level the bus settles to, so an external driver that forces a pin to a new value wins. The keeper then holds that value after the driver lets go.

The parity keepers stay on at all times. The data keepers switch on only in the two low-power states. In stop-grant with the clock running, a bus hold request is granted one clock later. During the grant every pin is floated and every keeper is switched off. The kept levels are frozen for the whole grant, so the bus comes back to its pre-hold levels once the request is withdrawn. In stop-clock, hold requests are ignored.

Top module: `bus_keeper_ctrl`

## Requirements
- R1: While the synchronized reset is active, `hlda` is 0 and every bit of `pin_out` is 0. The reset is asserted asynchronously and released synchronously two clock edges after `rst_n` rises.
- R2: Outside a granted hold, the parity keeper enables (`keep_en` bits 17:16) are 1 in every power state.
- R3: Outside a granted hold, the data keeper enables (`keep_en` bits 15:0) are 1 only when `pwr_state` is 2'b01 (stop-grant) or 2'b10 (stop-clock). They are 0 for 2'b00 and 2'b11 (running).
- R4: `hlda` rises on the first clock edge that samples `hold_req`=1 with `pwr_state`=2'b01 and `clk_run`=1. It falls on the first clock edge that samples `hold_req`=0 while it is high.
- R5: While `hlda` is 1, every bit of `keep_en` and `pin_oe` is 0 (the bus floats).
- R6: `pin_out` does not change while `hlda` is 1. After the hold ends, it still carries the levels it had when the hold was granted.
- R7: On each clock where a bit's keeper is enabled, its kept level takes the sampled `pin_in` level. This means an externally forced level is kept after the driver releases the pin.
- R8: A hold request is ignored in stop-clock (`pwr_state`=2'b10), in running mode, and whenever `clk_run` is 0.
- R9: `pin_oe` equals `keep_en` bit for bit, so the keeper drives `pin_out` exactly when it is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_state | input | 2 | 00 running, 01 stop-grant, 10 stop-clock, 11 running |
| hold_req | input | 1 | Bus hold request |
| clk_run | input | 1 | High when the processor clock is running |
| pin_in | input | 18 | Sampled levels of the pins (15:0 data, 17:16 parity) |
| hlda | output | 1 | Hold acknowledge |
| keep_en | output | 18 | Per-pin keeper enable |
| pin_oe | output | 18 | Per-pin tristate control, 1 = keeper drives |
| pin_out | output | 18 | Kept level driven onto each pin |

## Verification
The bench builds the block with its default widths, 16 data and 2 parity bits. This puts the boundary between the two keeper classes at bits 15 and 16, where a misplaced split would show up. Its pin model resolves each line from an external driver, from the keeper, or from a distinctive float pattern. As a result, a wrong output enable reaches the kept register and is detected. The sequences walk through every power-state code, holds granted and refused, and forced levels on both parity and data pins.

// File: rtl/bkc_pkg.sv
package bkc_pkg;

  typedef enum logic [1:0] {
    PWR_RUN  = 2'b00,
    PWR_SGNT = 2'b01,
    PWR_SCLK = 2'b10,
    PWR_ALT  = 2'b11
  } pwr_e;

  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_HELD = 1'b1
  } hold_st_e;

  function automatic logic is_low_power(input logic [1:0] st);
    return (st == PWR_SGNT) || (st == PWR_SCLK);
  endfunction

  function automatic logic hold_allowed(input logic [1:0] st, input logic run);
    return (st == PWR_SGNT) && run;
  endfunction

endpackage

// File: rtl/bkc_rst_sync.sv
module bkc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bkc_hold_fsm.sv
module bkc_hold_fsm
  import bkc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwr_state,
  input  logic       hold_req,
  input  logic       clk_run,
  output logic       held
);

  hold_st_e st_q;
  hold_st_e st_d;
  logic     st_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      HS_IDLE: if (hold_req && hold_allowed(pwr_state, clk_run)) st_d = HS_HELD;
      HS_HELD: if (!hold_req) st_d = HS_IDLE;
      default: st_d = HS_IDLE;
    endcase
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= HS_IDLE;
    end else if (st_en) begin
      st_q <= st_d;
    end
  end

  assign held = (st_q == HS_HELD);

endmodule

// File: rtl/bkc_enable_map.sv
module bkc_enable_map
  import bkc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PAR_W  = 2,
  localparam int BUS_W = DATA_W + PAR_W
) (
  input  logic [1:0]       pwr_state,
  input  logic             held,
  output logic [BUS_W-1:0] keep_en
);

  logic lp;
  assign lp = is_low_power(pwr_state);

  for (genvar i = 0; i < BUS_W; i++) begin : g_bit
    if (i < DATA_W) begin : g_data
      assign keep_en[i] = lp && !held;
    end else begin : g_par
      assign keep_en[i] = !held;
    end
  end

endmodule

// File: rtl/bkc_keep_reg.sv
module bkc_keep_reg #(
  parameter int BUS_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] sample_en,
  input  logic [BUS_W-1:0] pin_in,
  output logic [BUS_W-1:0] kept
);

  for (genvar i = 0; i < BUS_W; i++) begin : g_bit
    logic lvl_q;
    logic lvl_d;

    always_comb begin
      lvl_d = sample_en[i] ? pin_in[i] : lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q <= 1'b0;
      end else if (sample_en[i]) begin
        lvl_q <= lvl_d;
      end
    end

    assign kept[i] = lvl_q;
  end

endmodule

// File: rtl/bus_keeper_ctrl.sv
module bus_keeper_ctrl #(
  parameter int DATA_W = 16,
  parameter int PAR_W  = 2,
  localparam int BUS_W = DATA_W + PAR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       pwr_state,
  input  logic             hold_req,
  input  logic             clk_run,
  input  logic [BUS_W-1:0] pin_in,
  output logic             hlda,
  output logic [BUS_W-1:0] keep_en,
  output logic [BUS_W-1:0] pin_oe,
  output logic [BUS_W-1:0] pin_out
);

  logic             rst_sync_n;
  logic             held;
  logic [BUS_W-1:0] ken;

  bkc_rst_sync #(.STAGES(2)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bkc_hold_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pwr_state (pwr_state),
    .hold_req  (hold_req),
    .clk_run   (clk_run),
    .held      (held)
  );

  bkc_enable_map #(.DATA_W(DATA_W), .PAR_W(PAR_W)) i_map (
    .pwr_state (pwr_state),
    .held      (held),
    .keep_en   (ken)
  );

  bkc_keep_reg #(.BUS_W(BUS_W)) i_keep (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sample_en (ken),
    .pin_in    (pin_in),
    .kept      (pin_out)
  );

  assign hlda    = held;
  assign keep_en = ken;
  assign pin_oe  = ken;

endmodule

// File: rtl/bkc_chk.sv
module bkc_chk #(
  parameter int DATA_W = 16,
  parameter int PAR_W  = 2,
  localparam int BUS_W = DATA_W + PAR_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       pwr_state,
  input logic             hold_req,
  input logic             clk_run,
  input logic             hlda,
  input logic [BUS_W-1:0] keep_en,
  input logic [BUS_W-1:0] pin_oe,
  input logic [BUS_W-1:0] pin_out
);

  // R2
  parity_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hlda |-> (keep_en[BUS_W-1:DATA_W] == {PAR_W{1'b1}}));

  // R3
  data_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00 || pwr_state == 2'b11) |-> (keep_en[DATA_W-1:0] == '0));

  // R4
  grant_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hlda && hold_req && pwr_state == 2'b01 && clk_run) |=> hlda);

  // R4
  grant_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && !hold_req) |=> !hlda);

  // R5
  float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |-> (pin_oe == '0 && keep_en == '0));

  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlda |=> $stable(pin_out));

  // R8
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hlda && (pwr_state != 2'b01 || !clk_run)) |=> !hlda);

  // R9
  oe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe == keep_en);

endmodule

bind bus_keeper_ctrl bkc_chk #(.DATA_W(DATA_W), .PAR_W(PAR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .pwr_state (pwr_state),
  .hold_req  (hold_req),
  .clk_run   (clk_run),
  .hlda      (hlda),
  .keep_en   (keep_en),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out)
);

// File: tb/test_bus_keeper_ctrl.sv
`timescale 1ns/1ps
module test_bus_keeper_ctrl;

  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   pwr_state;
  logic         hold_req;
  logic         clk_run;
  logic [W-1:0] pin_in;
  logic         hlda;
  logic [W-1:0] keep_en;
  logic [W-1:0] pin_oe;
  logic [W-1:0] pin_out;

  logic [W-1:0] ext_en;
  logic [W-1:0] ext_val;
  logic [W-1:0] float_val;

  integer errors = 0;
  integer checks = 0;
  integer cycles = 0;
  logic   done   = 1'b0;

  always #4 clk = ~clk;

  bus_keeper_ctrl i_bus_keeper_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state), .hold_req(hold_req),
    .clk_run(clk_run), .pin_in(pin_in), .hlda(hlda), .keep_en(keep_en),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  // pin resolution: external driver, else keeper, else floating pattern
  always_comb begin
    for (int i = 0; i < W; i++) begin
      if (ext_en[i])      pin_in[i] = ext_val[i];
      else if (pin_oe[i]) pin_in[i] = pin_out[i];
      else                pin_in[i] = float_val[i];
    end
  end

  // reference model
  integer       m_rcnt;
  bit           m_held;
  logic [W-1:0] m_kept;

  function automatic logic [W-1:0] exp_ken();
    logic [W-1:0] r;
    bit lp;
    lp = (pwr_state == 2'd1) || (pwr_state == 2'd2);
    for (int i = 0; i < W; i++) begin
      if (m_held)       r[i] = 1'b0;
      else if (i >= 16) r[i] = 1'b1;
      else              r[i] = lp;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rcnt <= 0;
      m_held <= 1'b0;
      m_kept <= '0;
    end else if (m_rcnt < 2) begin
      m_rcnt <= m_rcnt + 1;
    end else begin
      logic [W-1:0] en;
      en = exp_ken();
      for (int i = 0; i < W; i++) if (en[i]) m_kept[i] <= pin_in[i];
      if (!m_held) begin
        if (hold_req && pwr_state == 2'd1 && clk_run) m_held <= 1'b1;
      end else if (!hold_req) begin
        m_held <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
      chk("R4 hlda", {31'd0, hlda}, {31'd0, m_held});
      chk("R3 R2 R5 keep_en", {14'd0, keep_en}, {14'd0, exp_ken()});
      chk("R9 pin_oe", {14'd0, pin_oe}, {14'd0, exp_ken()});
      chk("R7 R6 pin_out", {14'd0, pin_out}, {14'd0, m_kept});
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] saved;
    rst_n = 1'b0; pwr_state = 2'd0; hold_req = 1'b0; clk_run = 1'b1;
    ext_en = '0; ext_val = '0; float_val = 18'h2A5A5;
    #3;
    // R1 reset state
    chk("R1 hlda", {31'd0, hlda}, 32'd0);
    chk("R1 pin_out", {14'd0, pin_out}, 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 pin_out held in reset", {14'd0, pin_out}, 32'd0);
    cyc(3);

    // R2 parity keeper follows forced level in running mode
    ext_en = 18'h30000; ext_val = 18'h20000;
    cyc(2);
    ext_en = '0;
    cyc(3);
    chk("R2 parity keep_en running", {30'd0, keep_en[17:16]}, 32'd3);
    chk("R7 parity kept after release", {30'd0, pin_out[17:16]}, 32'd2);
    chk("R3 data keep_en off running", {16'd0, keep_en[15:0]}, 32'd0);

    // R3 alternate running code
    pwr_state = 2'd3; cyc(2);
    chk("R3 data keep_en off code 11", {16'd0, keep_en[15:0]}, 32'd0);

    // stop-grant: data keepers on, forced data kept
    pwr_state = 2'd1; cyc(1);
    chk("R3 data keep_en stop-grant", {16'd0, keep_en[15:0]}, 32'h0000FFFF);
    ext_en = 18'h0FFFF; ext_val = 18'h0C3A1;
    cyc(2);
    ext_en = '0;
    cyc(3);
    chk("R7 data kept after release", {14'd0, pin_out}, {14'd0, 18'h2C3A1});

    // R4 R5 R6 granted hold
    saved = pin_out;
    hold_req = 1'b1;
    #2; chk("R4 hlda not yet", {31'd0, hlda}, 32'd0);
    cyc(1);
    chk("R4 hlda one clock later", {31'd0, hlda}, 32'd1);
    chk("R5 float", {14'd0, pin_oe}, 32'd0);
    ext_en = '1; ext_val = 18'h15A5A;
    cyc(4);
    ext_en = '0;
    cyc(1);
    hold_req = 1'b0;
    cyc(1);
    chk("R4 hlda falls", {31'd0, hlda}, 32'd0);
    cyc(3);
    chk("R6 restored", {14'd0, pin_out}, {14'd0, saved});

    // R8 clk_run low
    clk_run = 1'b0; hold_req = 1'b1; cyc(4);
    chk("R8 refused without clock", {31'd0, hlda}, 32'd0);
    hold_req = 1'b0; clk_run = 1'b1;

    // R8 stop-clock
    pwr_state = 2'd2; hold_req = 1'b1; cyc(4);
    chk("R8 refused in stop-clock", {31'd0, hlda}, 32'd0);
    chk("R3 data keep_en stop-clock", {16'd0, keep_en[15:0]}, 32'h0000FFFF);
    ext_en = 18'h000F0; ext_val = 18'h0;
    cyc(2); ext_en = '0; cyc(2);
    hold_req = 1'b0;

    // R8 running mode
    pwr_state = 2'd0; hold_req = 1'b1; cyc(3);
    chk("R8 refused in running", {31'd0, hlda}, 32'd0);
    hold_req = 1'b0; cyc(1);

    // hold granted then power state changes during hold
    pwr_state = 2'd1; cyc(2);
    saved = pin_out;
    hold_req = 1'b1; cyc(2);
    pwr_state = 2'd0; cyc(2);
    chk("R5 still floating", {14'd0, keep_en}, 32'd0);
    hold_req = 1'b0; cyc(2);
    chk("R6 restored after mode change", {14'd0, pin_out}, {14'd0, saved});

    // asynchronous reset mid-run
    rst_n = 1'b0; #1;
    chk("R1 async reset", {14'd0, pin_out}, 32'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    cyc(4);

    done = 1'b1;
    finish_run();
  end

endmodule